// File: doc/BRIEF.md
# Boundary-Scan Register for a Dual 9-Bit Buffer

This block is the boundary-scan data register of a two-byte, non-inverting bus buffer. Each byte has nine data inputs, nine data outputs and two active-low enable pins. The buffer drives a byte only when both of that byte's enable pins are low. The register holds 42 cells on one serial path clocked by the test clock. Observe-only cells sit on every system input, which means the 18 data inputs and the four enable pins. Observe-and-control cells sit on the 18 data outputs and on the two internal, active-high byte enables that the buffer derives from its pins. Each controlling cell has a second stage that is loaded on the falling test clock. That stage can replace the system value at the pins.

The capture, shift and update strobes come from an external test-port state machine. A 3-bit mode code comes from an external instruction decoder. The mode code selects four things: whether the register is on the serial path, which cells a capture loads, whether the second stages drive the pins, and whether both bytes are forced off. The serial output goes to the test-data-out multiplexer.

Top module: `bscan_bsr`

## Requirements
- R1: An active-low `rst_n` clears every shift cell and every update stage to 0, so `tdo` reads 0. In any driving mode, both byte enables then read 0.
- R2: Mode codes 0 (system sample), 4 and 5 use system drive, and code 7 behaves as code 0. Under system drive each data output equals its data input. Each byte enable is 1 exactly when both of that byte's `*_oe_n` pins are 0.
- R3: Cell positions, with cell 0 next to `tdo`, are as follows. Cells 0-8 are `a_data_in[0..8]`. Cells 9-17 are `a_data_out`. Cells 18-26 are `b_data_in`. Cells 27-35 are `b_data_out`. Cell 36 is the A internal enable, cells 37 and 38 are `a_oe_n[0]` and `a_oe_n[1]`, cell 39 is the B internal enable, and cells 40 and 41 are `b_oe_n[0]` and `b_oe_n[1]`. In modes 0, 1 and 7, a rising `tck` with `capture_dr` high loads every cell with the value present at its pin or enable.
- R4: When the register is selected, a rising `tck` with `shift_dr` high and `capture_dr` low moves every cell one place toward cell 0 and loads `tdi` into cell 41. `tdo` always shows cell 0. `capture_dr` wins over `shift_dr`.
- R5: A falling `tck` with `update_dr` high copies the shift cells into the update stages of the 20 controlling cells (9-17, 27-36, 39). Shifting without an update leaves the driven outputs unchanged.
- R6: In mode 1 (external test), `a_data_out` is taken from cells 9-17, `b_data_out` from cells 27-35, `a_out_en` from cell 36 and `b_out_en` from cell 39, all from their update stages.
- R7: In mode 2 (clamp), the outputs are driven from the update stages as in R6. The register is deselected: capture, shift and update have no effect, and `tdo` holds.
- R8: In mode 3 (high impedance), both byte enables are 0 and the data outputs follow the inputs. The register is deselected as in R7.
- R9: In mode 4 (sample inputs), a capture loads only the observe-only cells. The controlling cells keep their shift values.
- R10: In mode 5 (sample outputs), a capture loads only the controlling cells. The observe-only cells keep their shift values.
- R11: In mode 6 (external test of outputs), the outputs are driven from the update stages as in R6. A capture loads only the observe-only cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous test-logic reset, active low |
| tdi | input | 1 | Serial data into cell 41 |
| mode_sel | input | 3 | Mode code from the instruction decoder |
| capture_dr | input | 1 | Capture strobe, sampled on rising tck |
| shift_dr | input | 1 | Shift strobe, sampled on rising tck |
| update_dr | input | 1 | Update strobe, sampled on falling tck |
| a_data_in | input | BYTE_W | Byte A system data inputs |
| a_oe_n | input | 2 | Byte A enable pins, active low |
| b_data_in | input | BYTE_W | Byte B system data inputs |
| b_oe_n | input | 2 | Byte B enable pins, active low |
| a_data_out | output | BYTE_W | Byte A data toward the output pins |
| a_out_en | output | 1 | Byte A internal enable, active high |
| b_data_out | output | BYTE_W | Byte B data toward the output pins |
| b_out_en | output | 1 | Byte B internal enable, active high |
| tdo | output | 1 | Serial output from cell 0 |

## Verification
The following rules are checked by the assertions on every rising edge:
- In system mode the data pins pass through.
- High-impedance mode keeps both enables low.
- A shift step moves cell 1 to the serial output.
- The chain stays frozen while clamp or high-impedance mode deselects it.
- A sample-inputs capture leaves the controlling cells untouched, and a sample-outputs capture leaves the observe-only cells untouched.

The bench's scenarios cover what a single-cycle property cannot show. It sweeps every mode code against changing data and enable-pin patterns. The cell map and the partial-capture masks are confirmed by scanning out whole captured vectors. It also shows that the update stages change only on a falling edge with an update strobe, and that clamp and high-impedance modes ignore all three strobes across a full scan.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   // Mode codes delivered by the instruction decoder; code 7 behaves as 0.
   typedef enum logic [2:0] {
      BSR_SYS      = 3'd0,
      BSR_EXT      = 3'd1,
      BSR_CLAMP    = 3'd2,
      BSR_HIZ      = 3'd3,
      BSR_OBS_IN   = 3'd4,
      BSR_OBS_OUT  = 3'd5,
      BSR_EXT_OUT  = 3'd6
   } bsr_mode_e;

   // Enable pins per byte; the cell map relies on this being 2.
   localparam int unsigned BSR_EN_PINS = 2;

   // Chain length for a given byte width.
   function automatic int unsigned bsr_len(int unsigned w);
      return 4 * w + 2 * (BSR_EN_PINS + 1);
   endfunction

   // 1 when the cell at pos is an observe-and-control cell.
   function automatic bit is_ctl_pos(int unsigned pos, int unsigned w);
      return (pos >= w && pos < 2 * w) ||
             (pos >= 3 * w && pos < 4 * w) ||
             (pos == 4 * w) ||
             (pos == 4 * w + BSR_EN_PINS + 1);
   endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
   parameter bit CONTROL = 1'b0
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic upd_en,
   input  logic cap_val,
   input  logic ser_in,
   output logic shift_q,
   output logic upd_q
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)        shift_q <= 1'b0;
      else if (cap_en)   shift_q <= cap_val;
      else if (shift_en) shift_q <= ser_in;
   end

   generate
      if (CONTROL) begin : g_ctl
         always_ff @(negedge tck or negedge rst_n) begin
            if (!rst_n)      upd_q <= 1'b0;
            else if (upd_en) upd_q <= shift_q;
         end
      end else begin : g_obs
         logic unused_upd_en;
         assign unused_upd_en = upd_en;
         assign upd_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bsr_mode_dec.sv
module bsr_mode_dec
   import bsr_pkg::*;
(
   input  logic [2:0] mode_sel,
   output logic       sel,
   output logic       cap_obs,
   output logic       cap_ctl,
   output logic       drive,
   output logic       force_off
);

   always_comb begin
      sel       = 1'b1;
      cap_obs   = 1'b1;
      cap_ctl   = 1'b1;
      drive     = 1'b0;
      force_off = 1'b0;
      case (bsr_mode_e'(mode_sel))
         BSR_EXT:     drive = 1'b1;
         BSR_CLAMP: begin
            sel   = 1'b0;
            drive = 1'b1;
         end
         BSR_HIZ: begin
            sel       = 1'b0;
            force_off = 1'b1;
         end
         BSR_OBS_IN:  cap_ctl = 1'b0;
         BSR_OBS_OUT: cap_obs = 1'b0;
         BSR_EXT_OUT: begin
            cap_ctl = 1'b0;
            drive   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bsr_byte_drive.sv
module bsr_byte_drive
   import bsr_pkg::*;
#(
   parameter int unsigned BYTE_W = 9
) (
   input  logic [BYTE_W-1:0]      sys_data,
   input  logic [BSR_EN_PINS-1:0] oe_n,
   input  logic [BYTE_W-1:0]      lat_data,
   input  logic                   lat_en,
   input  logic                   drive,
   input  logic                   force_off,
   output logic [BYTE_W-1:0]      pin_data,
   output logic                   pin_en
);

   logic sys_en;
   assign sys_en   = ~|oe_n;
   assign pin_data = drive ? lat_data : sys_data;

   always_comb begin
      if (force_off)  pin_en = 1'b0;
      else if (drive) pin_en = lat_en;
      else            pin_en = sys_en;
   end

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
   import bsr_pkg::*;
#(
   parameter int unsigned BYTE_W = 9
) (
   input  logic                   tck,
   input  logic                   rst_n,
   input  logic                   tdi,
   input  logic [2:0]             mode_sel,
   input  logic                   capture_dr,
   input  logic                   shift_dr,
   input  logic                   update_dr,
   input  logic [BYTE_W-1:0]      a_data_in,
   input  logic [BSR_EN_PINS-1:0] a_oe_n,
   input  logic [BYTE_W-1:0]      b_data_in,
   input  logic [BSR_EN_PINS-1:0] b_oe_n,
   output logic [BYTE_W-1:0]      a_data_out,
   output logic                   a_out_en,
   output logic [BYTE_W-1:0]      b_data_out,
   output logic                   b_out_en,
   output logic                   tdo
);

   localparam int unsigned N        = bsr_len(BYTE_W);
   localparam int unsigned AI_LO    = 0;
   localparam int unsigned AO_LO    = BYTE_W;
   localparam int unsigned BI_LO    = 2 * BYTE_W;
   localparam int unsigned BO_LO    = 3 * BYTE_W;
   localparam int unsigned A_EN_POS = 4 * BYTE_W;
   localparam int unsigned B_EN_POS = A_EN_POS + BSR_EN_PINS + 1;

   if (BYTE_W < 1 || BYTE_W > 32) begin : g_bad_width
      $error("bscan_bsr: BYTE_W must lie in 1..32");
   end

   logic sel, cap_obs, cap_ctl, drive, force_off;
   logic [N-1:0] chain_q;
   logic [N-1:0] upd_q;
   logic [N-1:0] cap_val;
   logic [N-1:0] ser;

   bsr_mode_dec u_dec (
      .mode_sel (mode_sel),
      .sel      (sel),
      .cap_obs  (cap_obs),
      .cap_ctl  (cap_ctl),
      .drive    (drive),
      .force_off(force_off)
   );

   bsr_byte_drive #(.BYTE_W(BYTE_W)) u_drv_a (
      .sys_data (a_data_in),
      .oe_n     (a_oe_n),
      .lat_data (upd_q[AO_LO +: BYTE_W]),
      .lat_en   (upd_q[A_EN_POS]),
      .drive    (drive),
      .force_off(force_off),
      .pin_data (a_data_out),
      .pin_en   (a_out_en)
   );

   bsr_byte_drive #(.BYTE_W(BYTE_W)) u_drv_b (
      .sys_data (b_data_in),
      .oe_n     (b_oe_n),
      .lat_data (upd_q[BO_LO +: BYTE_W]),
      .lat_en   (upd_q[B_EN_POS]),
      .drive    (drive),
      .force_off(force_off),
      .pin_data (b_data_out),
      .pin_en   (b_out_en)
   );

   // Values seen at each cell's pin or enable.
   assign cap_val[AI_LO +: BYTE_W] = a_data_in;
   assign cap_val[AO_LO +: BYTE_W] = a_data_out;
   assign cap_val[BI_LO +: BYTE_W] = b_data_in;
   assign cap_val[BO_LO +: BYTE_W] = b_data_out;
   assign cap_val[A_EN_POS]        = a_out_en;
   assign cap_val[A_EN_POS+1 +: BSR_EN_PINS] = a_oe_n;
   assign cap_val[B_EN_POS]        = b_out_en;
   assign cap_val[B_EN_POS+1 +: BSR_EN_PINS] = b_oe_n;

   assign ser = {tdi, chain_q[N-1:1]};
   assign tdo = chain_q[0];

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_cell
         localparam bit IS_CTL = is_ctl_pos(i, BYTE_W);
         logic cap_here;
         assign cap_here = capture_dr & sel & (IS_CTL ? cap_ctl : cap_obs);
         bsr_cell #(.CONTROL(IS_CTL)) u_cell (
            .tck     (tck),
            .rst_n   (rst_n),
            .cap_en  (cap_here),
            .shift_en(shift_dr & sel),
            .upd_en  (update_dr & sel),
            .cap_val (cap_val[i]),
            .ser_in  (ser[i]),
            .shift_q (chain_q[i]),
            .upd_q   (upd_q[i])
         );
      end
   endgenerate

   logic unused_upd_bits;
   assign unused_upd_bits = ^{upd_q[AI_LO +: BYTE_W], upd_q[BI_LO +: BYTE_W]};

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
   parameter int unsigned BYTE_W = 9
) (
   input logic                  tck,
   input logic                  rst_n,
   input logic [2:0]            mode_sel,
   input logic                  capture_dr,
   input logic                  shift_dr,
   input logic [BYTE_W-1:0]     a_data_in,
   input logic [BYTE_W-1:0]     b_data_in,
   input logic [BYTE_W-1:0]     a_data_out,
   input logic [BYTE_W-1:0]     b_data_out,
   input logic                  a_out_en,
   input logic                  b_out_en,
   input logic                  tdo,
   input logic [4*BYTE_W+5:0]   chain_q
);

   localparam int unsigned W = BYTE_W;

   AST_PASS_THROUGH: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_sel == 3'd0) |-> (a_data_out == a_data_in && b_data_out == b_data_in)); // R2

   AST_HIZ_ENABLES_OFF: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_sel == 3'd3) |-> (!a_out_en && !b_out_en)); // R8

   AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!rst_n)
      (shift_dr && !capture_dr && mode_sel != 3'd2 && mode_sel != 3'd3)
      |=> (tdo == $past(chain_q[1]))); // R4

   AST_DESELECT_FROZEN: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_sel == 3'd2 || mode_sel == 3'd3) |=> $stable(chain_q)); // R7

   AST_OBS_IN_KEEPS_CTL: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_sel == 3'd4 && capture_dr) |=>
      ($stable(chain_q[2*W-1:W]) && $stable(chain_q[4*W-1:3*W]))); // R9

   AST_OBS_OUT_KEEPS_OBS: assert property (@(posedge tck) disable iff (!rst_n)
      (mode_sel == 3'd5 && capture_dr) |=>
      ($stable(chain_q[W-1:0]) && $stable(chain_q[3*W-1:2*W]))); // R10

endmodule

bind bscan_bsr bsr_checker #(.BYTE_W(BYTE_W)) u_chk (
   .tck       (tck),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .capture_dr(capture_dr),
   .shift_dr  (shift_dr),
   .a_data_in (a_data_in),
   .b_data_in (b_data_in),
   .a_data_out(a_data_out),
   .b_data_out(b_data_out),
   .a_out_en  (a_out_en),
   .b_out_en  (b_out_en),
   .tdo       (tdo),
   .chain_q   (chain_q)
);

// File: tb/tb_bscan_bsr.sv
`timescale 1ns/1ps
module tb_bscan_bsr;
   localparam int W = 9;
   localparam int N = 4 * W + 6;

   logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic [W-1:0] a_data_in = '0, b_data_in = '0;
   logic [1:0] a_oe_n = 2'b11, b_oe_n = 2'b11;
   logic [W-1:0] a_data_out, b_data_out;
   logic a_out_en, b_out_en, tdo;

   bscan_bsr #(.BYTE_W(W)) dut (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .mode_sel(mode_sel),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .a_data_in(a_data_in), .a_oe_n(a_oe_n), .b_data_in(b_data_in), .b_oe_n(b_oe_n),
      .a_data_out(a_data_out), .a_out_en(a_out_en),
      .b_data_out(b_data_out), .b_out_en(b_out_en), .tdo(tdo)
   );

   always #2.5 tck = ~tck;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [N-1:0] mch = '0, mlat = '0;

   function automatic bit is_ctl(int i);
      return (i >= 9 && i <= 17) || (i >= 27 && i <= 35) || i == 36 || i == 39;
   endfunction
   function automatic bit m_drive(int m); return m == 1 || m == 2 || m == 6; endfunction
   function automatic bit m_sel(int m);   return !(m == 2 || m == 3); endfunction

   function automatic logic [2*W+1:0] exp_outs(int m);
      logic [W-1:0] ao, bo; logic ae, be;
      ao = m_drive(m) ? mlat[17:9]  : a_data_in;
      bo = m_drive(m) ? mlat[35:27] : b_data_in;
      ae = (m == 3) ? 1'b0 : m_drive(m) ? mlat[36] : (a_oe_n == 2'b00);
      be = (m == 3) ? 1'b0 : m_drive(m) ? mlat[39] : (b_oe_n == 2'b00);
      return {ao, ae, bo, be};
   endfunction

   function automatic logic [N-1:0] sys_vec(int m);
      logic [2*W+1:0] o; logic [N-1:0] v;
      o = exp_outs(m);
      v[8:0]   = a_data_in;
      v[17:9]  = o[2*W+1:W+2];
      v[26:18] = b_data_in;
      v[35:27] = o[W:1];
      v[36]    = o[W+1];
      v[38:37] = a_oe_n;
      v[39]    = o[0];
      v[41:40] = b_oe_n;
      return v;
   endfunction

   function automatic string out_tag(int m);
      case (m) 1: return "R6"; 2: return "R7"; 3: return "R8"; 6: return "R11"; default: return "R2"; endcase
   endfunction
   function automatic string cap_tag(int m);
      case (m) 2: return "R7"; 3: return "R8"; 4: return "R9"; 5: return "R10"; 6: return "R11"; default: return "R3"; endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_outputs(input int m, input string req);
      logic [2*W+1:0] e, a;
      e = exp_outs(m);
      a = {a_data_out, a_out_en, b_data_out, b_out_en};
      chk(a == e, req, 64'(a), 64'(e));
   endtask

   task automatic do_capture(input int m);
      capture_dr = 1'b1; @(posedge tck); #1; capture_dr = 1'b0;
   endtask

   task automatic model_capture(input int m);
      logic [N-1:0] s;
      s = sys_vec(m);
      if (m_sel(m))
         for (int i = 0; i < N; i++)
            if ((m == 4 || m == 6) ? !is_ctl(i) : (m == 5) ? is_ctl(i) : 1'b1) mch[i] = s[i];
   endtask

   task automatic do_update(input int m);
      update_dr = 1'b1; @(negedge tck); #1; update_dr = 1'b0;
      if (m_sel(m))
         for (int i = 0; i < N; i++) if (is_ctl(i)) mlat[i] = mch[i];
   endtask

   task automatic do_scan(input int m, input logic [N-1:0] din, input string req);
      logic [N-1:0] dout, e;
      for (int i = 0; i < N; i++) e[i] = m_sel(m) ? mch[i] : mch[0];
      shift_dr = 1'b1;
      for (int k = 0; k < N; k++) begin
         dout[k] = tdo; tdi = din[k];
         @(posedge tck); #1;
      end
      shift_dr = 1'b0;
      if (m_sel(m)) mch = din;
      chk(dout == e, req, 64'(dout), 64'(e));
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] pat;
      #12 rst_n = 1'b1;
      @(posedge tck); #1;
      chk(tdo == 1'b0, "R1", 64'(tdo), 0);
      mode_sel = 3'd1; #1;
      chk({a_out_en, b_out_en, a_data_out} == '0, "R1",
          64'({a_out_en, b_out_en, a_data_out}), 0);
      mode_sel = 3'd0; a_data_in = 9'h1A5; b_data_in = 9'h05A; a_oe_n = 2'b00; #1;
      chk_outputs(0, "R2");
      do_scan(0, '0, "R1");
      for (int m = 0; m < 8; m++) begin
         for (int it = 0; it < 4; it++) begin
            mode_sel  = 3'(m);
            a_data_in = W'(it * 73 + m * 11 + 5);
            b_data_in = W'(~(it * 29 + m * 51));
            a_oe_n    = 2'(it);
            b_oe_n    = 2'(~it);
            #1;
            chk_outputs(m, out_tag(m));
            pat = N'(64'(it * 64'h9E3779B97F4A7C15 + m * 64'h51ED27 + 64'h3C5));
            do_scan(m, pat, (m_sel(m)) ? "R4" : cap_tag(m));
            chk_outputs(m, "R5");
            do_update(m);
            chk_outputs(m, (m == 1) ? "R5" : out_tag(m));
            do_capture(m);
            model_capture(m);
            do_scan(m, ~pat, cap_tag(m));
         end
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule